// File: doc/BRIEF.md
# DMA Command-Queue Register Stub

This block is the software-visible control face of a host-to-controller DMA engine, with the data mover left out. Firmware programs a command-queue base address and an end pointer, then advances a write pointer to post work. The block does not fetch descriptors or move data. Every posted write-pointer update is treated as finished at once: the read pointer catches up to the write pointer, and both completion flags (upstream and downstream) are raised in the status register.

An interrupt-control register selects which completion flags drive the single level-sensitive interrupt line. Software acknowledges a flag by writing a one to its status bit. Firmware can write a special key value into the read-pointer register to arm a one-shot suppression. The next write-pointer update then moves the pointers but reports no completion. Access uses a simple 32-bit register bus with select, enable and write strobes. A write takes effect on the clock edge where select and enable are both high.

Top module: `cmdq_reg_stub`

## Requirements
- R1: After reset, base, end, write pointer, read pointer and interrupt control read zero, the status register reads STAT_RST (default 0x0000F800), the one-shot suppression is disarmed and `irq_o` is low.
- R2: The queue base register (byte offset 0x10) stores all 32 written bits and reads them back unchanged.
- R3: The queue end register (offset 0x14) stores the written data ANDed with PTR_MASK (default 0x000FFFF0).
- R4: A write to the write-pointer register (offset 0x18) stores the data ANDed with PTR_MASK, and in the same edge loads that same masked value into the read-pointer register (offset 0x1C).
- R5: A write-pointer write made while suppression is disarmed sets status bit 4 (upstream done) and bit 5 (downstream done). Both bits are readable, and the interrupt reflects them, in the first cycle after the write edge.
- R6: The interrupt-control register (offset 0x20) stores the written data ANDed with 0xBFEFF07F. Its bit 4 enables the upstream and its bit 5 the downstream completion interrupt.
- R7: `irq_o` is high exactly while status bit 4 is set with control bit 4 set, or status bit 5 is set with control bit 5 set. Other status bits never drive it.
- R8: Writing to the status register (offset 0x24) clears every bit written as one and leaves every bit written as zero unchanged, including the reset-time bits 11 to 15.
- R9: Software writes never change the read-pointer register. Writing the key 0xEE882266 there arms the one-shot suppression; any other value has no effect.
- R10: The first write-pointer write after arming updates both pointers, sets no status bit, and disarms suppression, so the following write-pointer write completes normally.
- R11: Reads at byte addresses at or beyond WIN_BYTES (default 0x30), or at unmapped offsets inside the window, return zero. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the current register state, zero when not selected |
| irq_o | output | 1 | Level interrupt for enabled completions |

## Verification
Every register write lands on the clock edge of its access phase. Read data is combinational, so a read issued in the cycle after a write must already show the new value, and a completion caused by a write-pointer write must be visible in both the status read and `irq_o` one cycle after that edge with no further delay. The bench commits each write at a rising edge and returns at the following falling edge. It then samples `irq_o` or `prdata` one time unit later. Each expected value is queued to the scoreboard only at that sampling instant, so no check can look before the result is due or wait past a later write.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int unsigned OFF_BASE = 32'h10;
  localparam int unsigned OFF_END  = 32'h14;
  localparam int unsigned OFF_WPTR = 32'h18;
  localparam int unsigned OFF_RPTR = 32'h1C;
  localparam int unsigned OFF_CTRL = 32'h20;
  localparam int unsigned OFF_STAT = 32'h24;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BASE,
    SEL_END,
    SEL_WPTR,
    SEL_RPTR,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;

endpackage

// File: rtl/cmdq_addr_dec.sv
module cmdq_addr_dec
  import cmdq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 32'h30
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WIN_BYTES);

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i < WIN_LIMIT) begin
      case (addr_i)
        ADDR_W'(OFF_BASE): sel_o = SEL_BASE;
        ADDR_W'(OFF_END):  sel_o = SEL_END;
        ADDR_W'(OFF_WPTR): sel_o = SEL_WPTR;
        ADDR_W'(OFF_RPTR): sel_o = SEL_RPTR;
        ADDR_W'(OFF_CTRL): sel_o = SEL_CTRL;
        ADDR_W'(OFF_STAT): sel_o = SEL_STAT;
        default:           sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cmdq_queue_regs.sv
module cmdq_queue_regs #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] PTR_MASK = 32'h000F_FFF0,
  parameter logic [31:0] ARM_KEY  = 32'hEE88_2266
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base_i,
  input  logic              wr_end_i,
  input  logic              wr_wptr_i,
  input  logic              wr_rptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] end_o,
  output logic [DATA_W-1:0] wptr_o,
  output logic [DATA_W-1:0] rptr_o,
  output logic              armed_o,
  output logic              done_o
);

  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(PTR_MASK);
  localparam logic [DATA_W-1:0] KEY_W  = DATA_W'(ARM_KEY);

  logic [DATA_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] end_q,  end_d;
  logic [DATA_W-1:0] wptr_q, wptr_d;
  logic [DATA_W-1:0] rptr_q, rptr_d;
  logic              armed_q, armed_d;
  logic              en_q;

  // one shared clock enable: any access that can touch this bank
  assign en_q = wr_base_i | wr_end_i | wr_wptr_i | wr_rptr_i;

  always_comb begin
    base_d  = base_q;
    end_d   = end_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    armed_d = armed_q;
    if (wr_base_i) base_d = wdata_i;
    if (wr_end_i)  end_d  = wdata_i & MASK_W;
    if (wr_wptr_i) begin
      wptr_d  = wdata_i & MASK_W;
      rptr_d  = wdata_i & MASK_W;
      armed_d = 1'b0;
    end
    if (wr_rptr_i && (wdata_i == KEY_W)) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      end_q   <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      armed_q <= 1'b0;
    end else if (en_q) begin
      base_q  <= base_d;
      end_q   <= end_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      armed_q <= armed_d;
    end
  end

  assign base_o  = base_q;
  assign end_o   = end_q;
  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign armed_o = armed_q;
  assign done_o  = wr_wptr_i & ~armed_q;

endmodule

// File: rtl/cmdq_irq_regs.sv
module cmdq_irq_regs #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] CTRL_MASK = 32'hBFEF_F07F,
  parameter logic [31:0] STAT_RST  = 32'h0000_F800,
  parameter int          FIRST_SRC = 4,
  parameter int          NUM_SRC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] CMASK_W  = DATA_W'(CTRL_MASK);
  localparam logic [DATA_W-1:0] SRST_W   = DATA_W'(STAT_RST);
  localparam logic [DATA_W-1:0] DONE_SET = DATA_W'(((1 << NUM_SRC) - 1) << FIRST_SRC);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] stat_q, stat_d;
  logic              ctrl_en, stat_en;
  logic [NUM_SRC-1:0] src_hit;

  assign ctrl_en = wr_ctrl_i;
  assign stat_en = wr_stat_i | done_i;

  always_comb begin
    ctrl_d = wr_ctrl_i ? (wdata_i & CMASK_W) : ctrl_q;
    stat_d = stat_q;
    if (wr_stat_i) stat_d = stat_d & ~wdata_i;
    if (done_i)    stat_d = stat_d | DONE_SET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= SRST_W;
    else if (stat_en) stat_q <= stat_d;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign src_hit[k] = stat_q[FIRST_SRC+k] & ctrl_q[FIRST_SRC+k];
  end

  assign irq_o  = |src_hit;
  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;

endmodule

// File: rtl/cmdq_reg_stub.sv
module cmdq_reg_stub
  import cmdq_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          WIN_BYTES = 32'h30,
  parameter logic [31:0] PTR_MASK  = 32'h000F_FFF0,
  parameter logic [31:0] CTRL_MASK = 32'hBFEF_F07F,
  parameter logic [31:0] STAT_RST  = 32'h0000_F800,
  parameter logic [31:0] ARM_KEY   = 32'hEE88_2266
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              irq_o
);

  localparam int DATA_W = 32;

  reg_sel_e    sel;
  logic        wr_en;
  logic [31:0] base_q, end_q, wptr_q, rptr_q, ctrl_q, stat_q;
  logic        armed_q, done;

  assign wr_en = psel & penable & pwrite;

  cmdq_addr_dec #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) dec_i (
    .addr_i (paddr),
    .sel_o  (sel)
  );

  cmdq_queue_regs #(.DATA_W(DATA_W), .PTR_MASK(PTR_MASK), .ARM_KEY(ARM_KEY)) queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_base_i (wr_en && sel == SEL_BASE),
    .wr_end_i  (wr_en && sel == SEL_END),
    .wr_wptr_i (wr_en && sel == SEL_WPTR),
    .wr_rptr_i (wr_en && sel == SEL_RPTR),
    .wdata_i   (pwdata),
    .base_o    (base_q),
    .end_o     (end_q),
    .wptr_o    (wptr_q),
    .rptr_o    (rptr_q),
    .armed_o   (armed_q),
    .done_o    (done)
  );

  cmdq_irq_regs #(.DATA_W(DATA_W), .CTRL_MASK(CTRL_MASK), .STAT_RST(STAT_RST),
                  .FIRST_SRC(4), .NUM_SRC(2)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_en && sel == SEL_CTRL),
    .wr_stat_i (wr_en && sel == SEL_STAT),
    .wdata_i   (pwdata),
    .done_i    (done),
    .ctrl_o    (ctrl_q),
    .stat_o    (stat_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (sel)
        SEL_BASE: prdata = base_q;
        SEL_END:  prdata = end_q;
        SEL_WPTR: prdata = wptr_q;
        SEL_RPTR: prdata = rptr_q;
        SEL_CTRL: prdata = ctrl_q;
        SEL_STAT: prdata = stat_q;
        default:  prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/cmdq_stub_chk.sv
module cmdq_stub_chk #(
  parameter int          ADDR_W    = 8,
  parameter int          WIN_BYTES = 32'h30,
  parameter logic [31:0] PTR_MASK  = 32'h000F_FFF0,
  parameter logic [31:0] CTRL_MASK = 32'hBFEF_F07F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              irq_o,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       stat_q,
  input logic [31:0]       rptr_q,
  input logic              armed_q
);

  logic wr_any, wr_wptr, wr_ctrl, wr_stat, out_win;
  assign wr_any  = psel & penable & pwrite;
  assign wr_wptr = wr_any && paddr == ADDR_W'(32'h18);
  assign wr_ctrl = wr_any && paddr == ADDR_W'(32'h20);
  assign wr_stat = wr_any && paddr == ADDR_W'(32'h24);
  assign out_win = paddr >= ADDR_W'(WIN_BYTES);

  // R4
  wptr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wptr |=> rptr_q == ($past(pwdata) & PTR_MASK));

  // R5
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wptr && !armed_q) |=> stat_q[5:4] == 2'b11);

  // R6
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == ($past(pwdata) & CTRL_MASK));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[5:4] == 2'b00) |-> !irq_o);

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (stat_q & $past(pwdata)) == 32'h0);

  // R10
  armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wptr && armed_q) |=> ($stable(stat_q) && !armed_q));

  // R11
  out_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && out_win) |-> prdata == 32'h0);

endmodule

bind cmdq_reg_stub cmdq_stub_chk #(
  .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .PTR_MASK(PTR_MASK), .CTRL_MASK(CTRL_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o),
  .ctrl_q(ctrl_q), .stat_q(stat_q), .rptr_q(rptr_q), .armed_q(armed_q)
);

// File: tb/cmdq_reg_stub_tb_top.sv
`timescale 1ns/1ps
module cmdq_reg_stub_tb_top;

  localparam logic [31:0] PMASK = 32'h000F_FFF0;
  localparam logic [31:0] CMASK = 32'hBFEF_F07F;
  localparam logic [31:0] SRST  = 32'h0000_F800;
  localparam logic [31:0] KEY   = 32'hEE88_2266;

  localparam logic [7:0] A_BASE = 8'h10, A_END = 8'h14, A_WPTR = 8'h18,
                         A_RPTR = 8'h1C, A_CTRL = 8'h20, A_STAT = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmdq_reg_stub #(.ADDR_W(8), .WIN_BYTES(32'h30), .PTR_MASK(PMASK),
                  .CTRL_MASK(CMASK), .STAT_RST(SRST), .ARM_KEY(KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
  );

  // scoreboard
  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  event        sample_ev;

  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [31:0] e, a;
        bit          k;
        string       t;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        a = k ? {31'b0, irq_o} : prdata;
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=0x%08h expected=0x%08h", t, a, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = a;
    #1;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    -> sample_ev;
    #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string t);
    #1;
    exp_q.push_back({31'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    -> sample_ev;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    irq_chk(1'b0, "R1 irq after reset");
    rd_chk(A_BASE, 32'h0, "R1 base reset");
    rd_chk(A_END,  32'h0, "R1 end reset");
    rd_chk(A_WPTR, 32'h0, "R1 wptr reset");
    rd_chk(A_RPTR, 32'h0, "R1 rptr reset");
    rd_chk(A_CTRL, 32'h0, "R1 ctrl reset");
    rd_chk(A_STAT, SRST,  "R1 status reset");

    // R2 base full width
    bus_wr(A_BASE, 32'h1234_5678);
    rd_chk(A_BASE, 32'h1234_5678, "R2 base store");

    // R3 end masked
    bus_wr(A_END, 32'hFFFF_FFFF);
    rd_chk(A_END, PMASK, "R3 end masked");

    // R4 / R5 pointer write completes at once
    bus_wr(A_WPTR, 32'hABCD_EF17);
    irq_chk(1'b0, "R7 no irq with ctrl clear");
    rd_chk(A_STAT, SRST | 32'h30, "R5 both done bits");
    rd_chk(A_WPTR, 32'hABCD_EF17 & PMASK, "R4 wptr masked");
    rd_chk(A_RPTR, 32'hABCD_EF17 & PMASK, "R4 rptr copy");

    // R6 ctrl masked, R7 irq
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    irq_chk(1'b1, "R7 irq enabled");
    rd_chk(A_CTRL, CMASK, "R6 ctrl masked");

    // R8 write-one-to-clear
    bus_wr(A_STAT, 32'h0000_0010);
    irq_chk(1'b1, "R7 irq held by bit5");
    rd_chk(A_STAT, SRST | 32'h20, "R8 clear bit4 only");
    bus_wr(A_STAT, 32'h0000_0020);
    irq_chk(1'b0, "R8 irq drops after clear");
    bus_wr(A_STAT, 32'h0000_0800);
    rd_chk(A_STAT, 32'h0000_F000, "R8 clear reset bit11");

    // R7 per-source enable, R5 timing
    bus_wr(A_CTRL, 32'h0000_0010);
    rd_chk(A_CTRL, 32'h0000_0010, "R6 ctrl bit4 only");
    bus_wr(A_WPTR, 32'h0000_0040);
    irq_chk(1'b1, "R5 irq first cycle after write");
    rd_chk(A_STAT, 32'h0000_F030, "R5 done bits again");
    bus_wr(A_STAT, 32'h0000_0010);
    irq_chk(1'b0, "R7 bit5 set but disabled");

    // R9 / R10 one-shot suppression
    bus_wr(A_RPTR, KEY);
    rd_chk(A_RPTR, 32'h0000_0040, "R9 rptr unchanged by key");
    bus_wr(A_STAT, 32'h0000_0020);
    bus_wr(A_WPTR, 32'h0000_0080);
    irq_chk(1'b0, "R10 no irq when armed");
    rd_chk(A_STAT, 32'h0000_F000, "R10 no completion when armed");
    rd_chk(A_RPTR, 32'h0000_0080, "R10 rptr still copied");
    bus_wr(A_WPTR, 32'h0000_00C4);
    irq_chk(1'b1, "R10 disarmed after one use");
    rd_chk(A_STAT, 32'h0000_F030, "R10 completion resumes");
    rd_chk(A_RPTR, 32'h0000_00C0, "R4 rptr masked copy");

    // R9 non-key write has no effect
    bus_wr(A_RPTR, 32'h0000_1234);
    rd_chk(A_RPTR, 32'h0000_00C0, "R9 rptr ignores plain write");
    bus_wr(A_STAT, 32'h0000_0030);
    bus_wr(A_WPTR, 32'h0000_0100);
    rd_chk(A_STAT, 32'h0000_F030, "R9 plain write did not arm");

    // R11 outside window and unmapped
    bus_wr(8'h50, 32'hFFFF_FFFF);
    bus_wr(8'h60, 32'hFFFF_FFFF);
    rd_chk(8'h50, 32'h0, "R11 read outside window");
    rd_chk(A_BASE, 32'h1234_5678, "R11 base untouched");
    rd_chk(A_CTRL, 32'h0000_0010, "R11 ctrl untouched");
    bus_wr(8'h28, 32'hFFFF_FFFF);
    rd_chk(8'h28, 32'h0, "R11 unmapped offset reads zero");
    rd_chk(A_STAT, 32'h0000_F030, "R11 status untouched");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule